// File: doc/BRIEF.md
# Dual Leaky Bucket Frame Policer

This block judges each incoming frame against two leaky buckets, a committed bucket and a peak bucket, and returns a pass or drop verdict. Each bucket keeps a 23-bit fill level. An accepted frame raises the fill of the bucket that accepted it. A fixed-period tick lowers each fill by the configured rate. When a bucket's fill is too high, that bucket rejects the frame. A frame is dropped only when both buckets reject it.

The frame cost depends on the accounting mode. Two modes count bytes: one adds the inter-packet gap to the frame length, and one does not. Two modes count frames at different resolutions. Burst limits are given in units of 4096 fill units. Optional coupling passes the unused committed drain on to the peak bucket. Software can write either fill level directly. Writing all ones forces that bucket to reject every frame. A peak rate of all ones together with a peak burst of zero turns the policer off.

Top module: `dlb_policer`

## Requirements
- R1: After reset both fill levels read 0 and verdictVld is low.
- R2: A frame strobed on frmVld produces verdictVld high with its verdictPass in the next cycle. verdictVld is low in every cycle that follows a cycle without frmVld.
- R3: The frame cost in fill units depends on cfgMode. Mode 0 costs frmLen+cfgIpg. Mode 1 costs frmLen. Mode 2 costs 125. Mode 3 costs 13653.
- R4: A bucket's limit is its burst field times 4096. With cfgOvershoot low, the bucket accepts when fill+cost <= limit. With cfgOvershoot high, it accepts when fill < limit.
- R5: The committed bucket is consulted first, and only while cfgCEnable is 1. If it rejects, the peak bucket is consulted. Only the bucket that passed the frame adds the cost to its fill. A dropped frame leaves both fills unchanged.
- R6: On a tick, each fill decreases by its rate field and saturates at 0.
- R7: With cfgCoupled and cfgCEnable both 1, the part of the committed rate left unused on a tick, max(cRate - fillC, 0), is added to the peak bucket's drain for that tick.
- R8: A fill write takes priority over ticks and frames and is visible in the next cycle. With a fill of all ones (0x7FFFFF), that bucket rejects every frame.
- R9: When cfgPRate is 0xFFFF and cfgPBurst is 0, every frame passes and frames change neither fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 2 | Accounting mode (0 line, 1 data, 2 frame high res, 3 frame low res) |
| cfgIpg | input | 5 | Gap bytes added in mode 0 |
| cfgCRate | input | 16 | Committed drain per tick |
| cfgPRate | input | 16 | Peak drain per tick |
| cfgCBurst | input | 7 | Committed limit in 4096-unit steps |
| cfgPBurst | input | 7 | Peak limit in 4096-unit steps |
| cfgCoupled | input | 1 | Pass unused committed drain to the peak bucket |
| cfgCEnable | input | 1 | Use the committed bucket |
| cfgOvershoot | input | 1 | Accept while fill is below the limit |
| fillWrC | input | 1 | Write fillWrData to the committed fill |
| fillWrP | input | 1 | Write fillWrData to the peak fill |
| fillWrData | input | 23 | Fill write value |
| tick | input | 1 | Drain strobe |
| frmVld | input | 1 | Frame strobe |
| frmLen | input | 14 | Frame length in bytes |
| verdictVld | output | 1 | Verdict valid |
| verdictPass | output | 1 | 1 means pass, 0 means drop |
| fillC | output | 23 | Committed fill level |
| fillP | output | 23 | Peak fill level |

## Verification
A wrong fill level shows up in two places. The fill outputs carry it one cycle after the frame or tick that caused it. The verdicts also change, because later frames that should be near a limit land on the wrong side of it. The sweep runs every mode with and without overshoot, with and without the committed bucket, and with coupling on and off. It compares each verdict and both fills one cycle after each event against bench arithmetic, so a divergence is reported at the first event that differs.

// File: rtl/dlb_policer_pkg.sv
package dlb_policer_pkg;
  localparam int FILL_W      = 23;
  localparam int RATE_W      = 16;
  localparam int BURST_W     = 7;
  localparam int IPG_W       = 5;
  localparam int BURST_SHIFT = 12;
  localparam int COST_HI     = 125;
  localparam int COST_LO     = 13653;

  typedef enum logic [1:0] {
    MODE_LINE   = 2'd0,
    MODE_DATA   = 2'd1,
    MODE_FRM_HI = 2'd2,
    MODE_FRM_LO = 2'd3
  } modeE;

  // strobes from control to datapath: which bucket takes the frame cost
  typedef struct packed {
    logic addC;
    logic addP;
  } strobeT;
endpackage

// File: rtl/dlb_policer_dp.sv
module dlb_policer_dp
  import dlb_policer_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [IPG_W-1:0]  ipg,
  input  logic [RATE_W-1:0] cRate,
  input  logic [RATE_W-1:0] pRate,
  input  logic              coupled,
  input  logic              cEnable,
  input  logic              tick,
  input  logic [LEN_W-1:0]  frmLen,
  input  strobeT            strobe,
  input  logic              wrC,
  input  logic              wrP,
  input  logic [FILL_W-1:0] wrData,
  output logic [FILL_W-1:0] fillC,
  output logic [FILL_W-1:0] fillP,
  output logic [FILL_W-1:0] frmSize
);
  logic [FILL_W-1:0] cRateExt, cAfter, pAfter, cSpare, pDrain;
  logic [FILL_W:0]   cSum, pSum;
  logic [FILL_W-1:0] cNext, pNext;

  always_comb begin
    unique case (modeE'(mode))
      MODE_LINE:   frmSize = FILL_W'(frmLen) + FILL_W'(ipg);
      MODE_DATA:   frmSize = FILL_W'(frmLen);
      MODE_FRM_HI: frmSize = FILL_W'(COST_HI);
      default:     frmSize = FILL_W'(COST_LO);
    endcase
  end

  always_comb begin
    cRateExt = FILL_W'(cRate);
    cSpare   = '0;
    if (fillC >= cRateExt) cAfter = fillC - cRateExt;
    else begin
      cAfter = '0;
      cSpare = cRateExt - fillC;
    end
    pDrain = FILL_W'(pRate) + ((coupled && cEnable) ? cSpare : '0);
    pAfter = (fillP >= pDrain) ? fillP - pDrain : '0;
    if (!tick) begin
      cAfter = fillC;
      pAfter = fillP;
    end
    cSum  = {1'b0, cAfter} + {1'b0, (strobe.addC ? frmSize : '0)};
    pSum  = {1'b0, pAfter} + {1'b0, (strobe.addP ? frmSize : '0)};
    cNext = cSum[FILL_W] ? '1 : cSum[FILL_W-1:0];
    pNext = pSum[FILL_W] ? '1 : pSum[FILL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillC <= '0;
      fillP <= '0;
    end else begin
      fillC <= wrC ? wrData : cNext;
      fillP <= wrP ? wrData : pNext;
    end
  end

  // R8: a written value lands in the next cycle
  a_r8_write_lands_c: assert property (@(posedge clk) disable iff (!rstN)
    wrC |=> fillC == $past(wrData));
  a_r8_write_lands_p: assert property (@(posedge clk) disable iff (!rstN)
    wrP |=> fillP == $past(wrData));
  // R5/R6: without an accepted frame or a write, a fill never grows
  a_r5_no_growth_c: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.addC && !wrC) |=> fillC <= $past(fillC));
  a_r5_no_growth_p: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.addP && !wrP) |=> fillP <= $past(fillP));
endmodule

// File: rtl/dlb_policer_ctrl.sv
module dlb_policer_ctrl
  import dlb_policer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               frmVld,
  input  logic [FILL_W-1:0]  fillC,
  input  logic [FILL_W-1:0]  fillP,
  input  logic [FILL_W-1:0]  frmSize,
  input  logic [BURST_W-1:0] cBurst,
  input  logic [BURST_W-1:0] pBurst,
  input  logic [RATE_W-1:0]  pRate,
  input  logic               cEnable,
  input  logic               overshoot,
  output strobeT             strobe,
  output logic               verdictVld,
  output logic               verdictPass
);
  logic [FILL_W-1:0] cLimit, pLimit;
  logic cOk, pOk, bypass;

  function automatic logic accepts(input logic [FILL_W-1:0] fill,
                                   input logic [FILL_W-1:0] size,
                                   input logic [FILL_W-1:0] limit,
                                   input logic ovs);
    if (ovs) return fill < limit;
    return ({1'b0, fill} + {1'b0, size}) <= {1'b0, limit};
  endfunction

  always_comb begin
    cLimit      = FILL_W'(cBurst) << BURST_SHIFT;
    pLimit      = FILL_W'(pBurst) << BURST_SHIFT;
    bypass      = (pBurst == '0) && (pRate == '1);
    cOk         = cEnable && accepts(fillC, frmSize, cLimit, overshoot);
    pOk         = accepts(fillP, frmSize, pLimit, overshoot);
    strobe.addC = frmVld && !bypass && cOk;
    strobe.addP = frmVld && !bypass && !cOk && pOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      verdictVld  <= 1'b0;
      verdictPass <= 1'b0;
    end else begin
      verdictVld  <= frmVld;
      verdictPass <= frmVld && (bypass || cOk || pOk);
    end
  end

  a_r2_verdict_follows: assert property (@(posedge clk) disable iff (!rstN)
    frmVld |=> verdictVld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !frmVld |=> !verdictVld);
  a_r9_bypass_passes: assert property (@(posedge clk) disable iff (!rstN)
    (frmVld && pRate == '1 && pBurst == '0) |=> verdictPass);
  a_r8_full_rejects: assert property (@(posedge clk) disable iff (!rstN)
    (frmVld && fillC == '1 && fillP == '1 && !(pRate == '1 && pBurst == '0))
      |=> !verdictPass);
endmodule

// File: rtl/dlb_policer.sv
module dlb_policer
  import dlb_policer_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgMode,
  input  logic [IPG_W-1:0]   cfgIpg,
  input  logic [RATE_W-1:0]  cfgCRate,
  input  logic [RATE_W-1:0]  cfgPRate,
  input  logic [BURST_W-1:0] cfgCBurst,
  input  logic [BURST_W-1:0] cfgPBurst,
  input  logic               cfgCoupled,
  input  logic               cfgCEnable,
  input  logic               cfgOvershoot,
  input  logic               fillWrC,
  input  logic               fillWrP,
  input  logic [FILL_W-1:0]  fillWrData,
  input  logic               tick,
  input  logic               frmVld,
  input  logic [LEN_W-1:0]   frmLen,
  output logic               verdictVld,
  output logic               verdictPass,
  output logic [FILL_W-1:0]  fillC,
  output logic [FILL_W-1:0]  fillP
);
  strobeT            strobe;
  logic [FILL_W-1:0] frmSize;

  dlb_policer_dp #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .mode(cfgMode), .ipg(cfgIpg),
    .cRate(cfgCRate), .pRate(cfgPRate), .coupled(cfgCoupled),
    .cEnable(cfgCEnable), .tick(tick), .frmLen(frmLen), .strobe(strobe),
    .wrC(fillWrC), .wrP(fillWrP), .wrData(fillWrData),
    .fillC(fillC), .fillP(fillP), .frmSize(frmSize)
  );

  dlb_policer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frmVld(frmVld), .fillC(fillC), .fillP(fillP),
    .frmSize(frmSize), .cBurst(cfgCBurst), .pBurst(cfgPBurst),
    .pRate(cfgPRate), .cEnable(cfgCEnable), .overshoot(cfgOvershoot),
    .strobe(strobe), .verdictVld(verdictVld), .verdictPass(verdictPass)
  );
endmodule

// File: tb/dlb_policer_tb.sv
module dlb_policer_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] cfgMode = '0;
  logic [4:0] cfgIpg = 5'd20;
  logic [15:0] cfgCRate = '0, cfgPRate = '0;
  logic [6:0] cfgCBurst = '0, cfgPBurst = '0;
  logic cfgCoupled = 0, cfgCEnable = 0, cfgOvershoot = 0;
  logic fillWrC = 0, fillWrP = 0;
  logic [22:0] fillWrData = '0;
  logic tick = 0, frmVld = 0;
  logic [13:0] frmLen = '0;
  logic verdictVld, verdictPass;
  logic [22:0] fillC, fillP;

  int checks = 0, errors = 0;
  longint mC = 0, mP = 0;

  always #2.5 clk = ~clk;

  dlb_policer u_dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint cost(input int mode, input int len);
    case (mode)
      0: return len + cfgIpg;
      1: return len;
      2: return 125;
      default: return 13653;
    endcase
  endfunction

  function automatic bit acc(input longint fill, input longint sz,
                             input longint lim, input bit ovs);
    return ovs ? (fill < lim) : (fill + sz <= lim);
  endfunction

  task automatic setFills(input longint c, input longint p);
    @(negedge clk);
    fillWrC = 1; fillWrP = 1; fillWrData = 23'(c);
    @(negedge clk);
    fillWrC = 0; fillWrData = 23'(p);
    @(negedge clk);
    fillWrP = 0;
    mC = c; mP = p;
  endtask

  task automatic doTick(input string req);
    longint spare = 0, pd;
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
    if (mC >= cfgCRate) mC -= cfgCRate;
    else begin spare = cfgCRate - mC; mC = 0; end
    pd = cfgPRate + ((cfgCoupled && cfgCEnable) ? spare : 0);
    mP = (mP >= pd) ? mP - pd : 0;
    chk(req, fillC, mC);
    chk(req, fillP, mP);
  endtask

  task automatic frame(input int len, input string req);
    longint sz = cost(cfgMode, len);
    bit byp = (cfgPBurst == 0) && (cfgPRate == 16'hFFFF);
    bit cOk = cfgCEnable && acc(mC, sz, longint'(cfgCBurst) * 4096, cfgOvershoot);
    bit pOk = acc(mP, sz, longint'(cfgPBurst) * 4096, cfgOvershoot);
    bit expPass = byp || cOk || pOk;
    @(negedge clk);
    frmVld = 1; frmLen = 14'(len);
    @(negedge clk);
    frmVld = 0;
    if (!byp) begin
      if (cOk) mC += sz;
      else if (pOk) mP += sz;
    end
    chk({req, " vld"}, verdictVld, 1);
    chk({req, " pass"}, verdictPass, expPass);
    chk({req, " fillC"}, fillC, mC);
    chk({req, " fillP"}, fillP, mP);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 fillC", fillC, 0);
    chk("R1 fillP", fillP, 0);
    chk("R1 vld", verdictVld, 0);

    // sweep over R3 R4 R5 R6 R7: all modes, overshoot, committed enable
    cfgCRate = 16'd3000; cfgPRate = 16'd1000;
    cfgCBurst = 7'd2; cfgPBurst = 7'd3;
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 2; o++) begin
        for (int e = 0; e < 2; e++) begin
          cfgMode = 2'(m); cfgOvershoot = o[0]; cfgCEnable = e[0];
          cfgCoupled = m[0];
          setFills(0, 0);
          for (int i = 0; i < 12; i++) begin
            frame(64 + i * 700, "R3 R4 R5 sweep");
            if (i % 3 == 2) doTick("R6 R7 drain");
          end
        end
      end
    end

    // R2: no verdict without a frame
    @(negedge clk);
    chk("R2 idle vld", verdictVld, 0);

    // R7: coupled spare drain raises peak drain
    cfgMode = 2'd1; cfgCEnable = 1; cfgCoupled = 1; cfgOvershoot = 0;
    setFills(1000, 5000);
    doTick("R7 coupled");
    chk("R7 peak after coupled", fillP, 2000);

    // R8: all-ones fill forces drops
    setFills(23'h7FFFFF, 23'h7FFFFF);
    chk("R8 write visible", fillC, 23'h7FFFFF);
    frame(64, "R8 full");
    chk("R8 dropped", verdictPass, 0);

    // R9: bypass setting passes all and leaves fills untouched
    cfgPRate = 16'hFFFF; cfgPBurst = 7'd0;
    frame(1500, "R9 bypass");
    chk("R9 pass", verdictPass, 1);
    chk("R9 fillP kept", fillP, 23'h7FFFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule